// File: doc/BRIEF.md
# Descriptor-Chain DMA Engine

This block moves data between system memory and a peripheral FIFO by walking a linked list of descriptors held in memory. Each descriptor is four consecutive 32-bit words. Software writes the address of the first descriptor into the head register, then writes the control register with the enable bit set. The engine then waits for the command-response-end event from the host controller. After that event it fetches each descriptor, moves that descriptor's segment, and follows the next pointer. It stops when a descriptor carries the end flag and then pulses `dma_end`.

The direction bit in the control word selects the path. Memory-to-FIFO reads buffer words and presents them on the outbound FIFO port. FIFO-to-memory takes words from the inbound FIFO port and writes them to memory with byte strobes. A buffer that does not start on a word boundary is handled through the alignment fields of the control word, which mask the unused leading bytes of the first data beat. The memory port allows one request in flight and carries a valid/ready request channel with a separate read-response strobe.

Register map:
- `cfg_sel` = 0 selects the head register, which takes all 32 bits of `cfg_wdata`.
- `cfg_sel` = 1 selects the control register:
  - bit 0: enable
  - bit 1: direction (1 = memory to FIFO)
  - bits 3:2: burst setting, accepted but with no effect on the beat sequence
  - bit 4: alignment enable
  - bits 6:5: leading byte offset

Descriptor words, at byte offsets +0, +4, +8 and +12 from the descriptor address:
- +0: next-descriptor address
- +4: buffer address
- +8: byte length, low 16 bits used
- +12: command word
  - bit 0: link flag
  - bit 1: end flag
  - bits 31:16: the descriptor's index in the chain

Top module: `dlc_engine`

## Requirements
- R1: After reset `busy` and `dma_end` are 0. No memory request is made, `fifo_out_valid` is 0 and `fifo_in_ready` is 0. While `busy` is 0 all three stay low.
- R2: A control write (`cfg_sel`=1) with bit 0 set arms the engine and raises `busy`. No memory request is issued until `resp_done` is seen while armed. A `resp_done` pulse while idle has no effect.
- R3: Each descriptor is fetched with four reads, at its address +0, +4, +8 and +12 in that order. All four complete before any data request for that segment.
- R4: Descriptor word +0 is the next address, +4 is the buffer address, +8 is the byte length and +12 is the command. When command bit 1 (end) is set, that segment is the last one. Otherwise the engine fetches the descriptor at the next address. The index bits 31:16 of the command word do not change the transfer.
- R5: With control bit 1 = 1, every data beat is one memory read at consecutive word addresses, starting at the buffer address with bits 1:0 cleared. The read word is presented on `fifo_out_data`, with `fifo_out_keep` equal to that beat's byte mask.
- R6: With control bit 1 = 0, each word accepted on the inbound FIFO port is written to memory at consecutive word addresses, in order, with `mem_req_strb` equal to the beat's byte mask.
- R7: With control bit 4 set, the first data beat of the chain enables only byte lanes from the offset in bits 6:5 upward. With bit 4 clear the offset field is ignored and lanes start at 0. All later beats start at lane 0.
- R8: A segment of L bytes that starts at lane o uses ceil((o+L)/4) beats. The last beat's mask covers only the remaining bytes. A zero-length segment produces no data beat.
- R9: `dma_end` is a one-cycle pulse that follows completion of the last beat of the end-flagged segment. `busy` is 0 in that same cycle.
- R10: A control write with bit 0 clear (for example zero) returns the engine to idle in the next cycle from any state. It raises no `dma_end`, and a later start runs normally.
- R11: After MAX_DESC descriptors (128 by default) the chain stops and raises `dma_end` even if no end flag was seen.
- R12: Back-pressure:
  - A memory request held while `mem_req_ready` is low keeps its valid, address, direction and write data unchanged.
  - An outbound FIFO beat held while `fifo_out_ready` is low keeps its data and keep unchanged.
  - The engine takes an inbound word only in a cycle where `fifo_in_valid` and `fifo_in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = head register, 1 = control register |
| cfg_wdata | input | 32 | Register write data |
| resp_done | input | 1 | Command-response-end event that releases an armed engine |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_req_strb | output | 4 | Byte enables for writes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| fifo_out_valid | output | 1 | Outbound FIFO beat valid |
| fifo_out_ready | input | 1 | Peripheral accepts the outbound beat |
| fifo_out_data | output | 32 | Outbound word |
| fifo_out_keep | output | 4 | Valid byte lanes of the outbound word |
| fifo_in_valid | input | 1 | Inbound FIFO word valid |
| fifo_in_ready | output | 1 | Engine takes the inbound word |
| fifo_in_data | input | 32 | Inbound word |
| busy | output | 1 | Engine armed or running |
| dma_end | output | 1 | One-cycle chain-complete pulse |

## Verification
The assertions take the following for granted about the inputs:
- The memory returns exactly one `mem_rsp_valid` pulse for each accepted read, no earlier than the cycle after acceptance.
- No response is still outstanding when a new transfer starts.
- Register writes are single-cycle strobes.

The bench memory model keeps to this by holding a single pending-read slot with a random delay of zero to two cycles. It leaves idle gaps after every completion and after the abort. It also drives `mem_req_ready`, `fifo_out_ready` and `fifo_in_valid` randomly, so the hold rules are exercised under stall.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ARMED, ST_FREQ, ST_FWAIT, ST_SEG,
    ST_DIN, ST_DREQ, ST_DWAIT, ST_DOUT
  } dlc_state_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_ALIGN = 4;
  localparam int CTL_OFF   = 5;
  localparam int CMD_END   = 1;
endpackage

// File: rtl/dlc_cfg_regs.sv
module dlc_cfg_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [AW-1:0] head_addr,
  output logic          dir_m2f,
  output logic [1:0]    lead_off,
  output logic          start_p,
  output logic          abort_p
);
  import dlc_pkg::*;

  logic ctl_wr;
  assign ctl_wr  = cfg_wr && cfg_sel;
  assign start_p = ctl_wr && cfg_wdata[CTL_EN];
  assign abort_p = ctl_wr && !cfg_wdata[CTL_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_addr <= '0;
      dir_m2f   <= 1'b0;
      lead_off  <= 2'd0;
    end else if (cfg_wr && !cfg_sel) begin
      head_addr <= cfg_wdata[AW-1:0];
    end else if (start_p) begin
      dir_m2f  <= cfg_wdata[CTL_DIR];
      lead_off <= cfg_wdata[CTL_ALIGN] ? cfg_wdata[CTL_OFF +: 2] : 2'd0;
    end
  end
endmodule

// File: rtl/dlc_lane_mask.sv
module dlc_lane_mask #(
  parameter int LEN_W = 16
) (
  input  logic [1:0]       off,
  input  logic [LEN_W-1:0] rem,
  output logic [3:0]       strb,
  output logic [2:0]       take
);
  logic [2:0] avail;
  assign avail = 3'd4 - {1'b0, off};
  assign take  = (rem < LEN_W'(avail)) ? rem[2:0] : avail;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign strb[g] = (3'(g) >= {1'b0, off}) && (3'(g) < ({1'b0, off} + take));
  end
endmodule

// File: rtl/dlc_desc_regs.sv
module dlc_desc_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [1:0]  sel,
  input  logic [31:0] din,
  output logic [31:0] w_next,
  output logic [31:0] w_buf,
  output logic [31:0] w_len,
  output logic [31:0] w_cmd
);
  logic [31:0] word_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    word_q[g] <= '0;
      else if (ld && sel == 2'(g))   word_q[g] <= din;
    end
  end

  assign w_next = word_q[0];
  assign w_buf  = word_q[1];
  assign w_len  = word_q[2];
  assign w_cmd  = word_q[3];
endmodule

// File: rtl/dlc_engine.sv
module dlc_engine #(
  parameter int AW       = 32,
  parameter int LEN_W    = 16,
  parameter int MAX_DESC = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          resp_done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  output logic [3:0]    mem_req_strb,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          fifo_out_valid,
  input  logic          fifo_out_ready,
  output logic [31:0]   fifo_out_data,
  output logic [3:0]    fifo_out_keep,
  input  logic          fifo_in_valid,
  output logic          fifo_in_ready,
  input  logic [31:0]   fifo_in_data,
  output logic          busy,
  output logic          dma_end
);
  import dlc_pkg::*;

  localparam int CNT_W = $clog2(MAX_DESC + 1);

  dlc_state_e       st_q;
  logic [AW-1:0]    head_addr, desc_addr, daddr;
  logic             dir_m2f, start_p, abort_p;
  logic [1:0]       lead_off, boff, wcnt;
  logic [CNT_W-1:0] nseg;
  logic [LEN_W-1:0] rem;
  logic [31:0]      data_q, w_next, w_buf, w_len, w_cmd;
  logic [3:0]       lane_strb;
  logic [2:0]       lane_take;
  logic             desc_ld, beat_done, last_desc;
  logic             unused_bits;

  dlc_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .head_addr(head_addr), .dir_m2f(dir_m2f),
    .lead_off(lead_off), .start_p(start_p), .abort_p(abort_p)
  );

  assign desc_ld = (st_q == ST_FWAIT) && mem_rsp_valid;

  dlc_desc_regs u_desc (
    .clk(clk), .rst_n(rst_n), .ld(desc_ld), .sel(wcnt), .din(mem_rsp_data),
    .w_next(w_next), .w_buf(w_buf), .w_len(w_len), .w_cmd(w_cmd)
  );

  dlc_lane_mask #(.LEN_W(LEN_W)) u_lane (
    .off(boff), .rem(rem), .strb(lane_strb), .take(lane_take)
  );

  assign beat_done = ((st_q == ST_DREQ) && mem_req_ready && !dir_m2f) ||
                     ((st_q == ST_DOUT) && fifo_out_ready);
  assign last_desc = w_cmd[CMD_END] || (nseg == CNT_W'(MAX_DESC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      desc_addr <= '0;
      daddr     <= '0;
      wcnt      <= 2'd0;
      nseg      <= '0;
      rem       <= '0;
      boff      <= 2'd0;
      data_q    <= '0;
      dma_end   <= 1'b0;
    end else begin
      dma_end <= 1'b0;
      if (abort_p) begin
        st_q <= ST_IDLE;
      end else begin
        if (beat_done) begin
          daddr <= daddr + AW'(4);
          rem   <= rem - LEN_W'(lane_take);
          boff  <= 2'd0;
        end
        unique case (st_q)
          ST_IDLE:  if (start_p) st_q <= ST_ARMED;
          ST_ARMED: if (resp_done) begin
            desc_addr <= head_addr;
            wcnt      <= 2'd0;
            nseg      <= '0;
            boff      <= lead_off;
            st_q      <= ST_FREQ;
          end
          ST_FREQ:  if (mem_req_ready) st_q <= ST_FWAIT;
          ST_FWAIT: if (mem_rsp_valid) begin
            wcnt <= wcnt + 2'd1;
            if (wcnt == 2'd3) begin
              daddr <= {w_buf[AW-1:2], 2'b00};
              rem   <= w_len[LEN_W-1:0];
              st_q  <= ST_SEG;
            end else begin
              st_q <= ST_FREQ;
            end
          end
          ST_SEG: begin
            if (rem != '0) begin
              st_q <= dir_m2f ? ST_DREQ : ST_DIN;
            end else if (last_desc) begin
              dma_end <= 1'b1;
              st_q    <= ST_IDLE;
            end else begin
              desc_addr <= w_next[AW-1:0];
              nseg      <= nseg + CNT_W'(1);
              st_q      <= ST_FREQ;
            end
          end
          ST_DIN:   if (fifo_in_valid) begin
            data_q <= fifo_in_data;
            st_q   <= ST_DREQ;
          end
          ST_DREQ:  if (mem_req_ready) st_q <= dir_m2f ? ST_DWAIT : ST_SEG;
          ST_DWAIT: if (mem_rsp_valid) begin
            data_q <= mem_rsp_data;
            st_q   <= ST_DOUT;
          end
          ST_DOUT:  if (fifo_out_ready) st_q <= ST_SEG;
          default:  st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy           = (st_q != ST_IDLE);
  assign mem_req_valid  = (st_q == ST_FREQ) || (st_q == ST_DREQ);
  assign mem_req_write  = (st_q == ST_DREQ) && !dir_m2f;
  assign mem_req_addr   = (st_q == ST_FREQ) ? desc_addr + AW'({wcnt, 2'b00}) : daddr;
  assign mem_req_wdata  = data_q;
  assign mem_req_strb   = (st_q == ST_FREQ) ? 4'hF : lane_strb;
  assign fifo_out_valid = (st_q == ST_DOUT);
  assign fifo_out_data  = data_q;
  assign fifo_out_keep  = lane_strb;
  assign fifo_in_ready  = (st_q == ST_DIN);

  assign unused_bits = ^{w_cmd[31:2], w_cmd[0], w_buf[1:0], w_len[31:LEN_W], w_next};
endmodule

// File: rtl/dlc_engine_chk.sv
module dlc_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          cfg_sel,
  input logic [31:0]   cfg_wdata,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic [3:0]    mem_req_strb,
  input logic          fifo_out_valid,
  input logic          fifo_out_ready,
  input logic [31:0]   fifo_out_data,
  input logic [3:0]    fifo_out_keep,
  input logic          fifo_in_ready,
  input logic          busy,
  input logic          dma_end
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_out_valid && !fifo_out_ready |=> fifo_out_valid && $stable(fifo_out_data)
      && $stable(fifo_out_keep));

  a_r9_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dma_end |=> !dma_end);

  a_r9_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dma_end |-> !busy);

  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_sel && !cfg_wdata[0] |=> !busy && !dma_end);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !fifo_out_valid && !fifo_in_ready);

  a_r8_strb_live: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_strb != 4'h0);

  a_r5_keep_live: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_out_valid |-> fifo_out_keep != 4'h0);
endmodule

bind dlc_engine dlc_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_req_strb(mem_req_strb), .fifo_out_valid(fifo_out_valid),
  .fifo_out_ready(fifo_out_ready), .fifo_out_data(fifo_out_data),
  .fifo_out_keep(fifo_out_keep), .fifo_in_ready(fifo_in_ready),
  .busy(busy), .dma_end(dma_end)
);

// File: tb/dlc_engine_test.sv
`timescale 1ns/1ps
module dlc_engine_test;
  localparam int MAXD = 128;
  localparam int LOGN = 1024;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_sel = 0, resp_done = 0;
  logic [31:0] cfg_wdata = 0;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data;
  logic [3:0] mem_req_strb, fifo_out_keep;
  logic fifo_out_valid, fifo_out_ready, fifo_in_valid, fifo_in_ready;
  logic [31:0] fifo_out_data, fifo_in_data;
  logic busy, dma_end;

  always #2.5 clk = ~clk;

  dlc_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .resp_done(resp_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_strb(mem_req_strb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fifo_out_valid(fifo_out_valid), .fifo_out_ready(fifo_out_ready),
    .fifo_out_data(fifo_out_data), .fifo_out_keep(fifo_out_keep),
    .fifo_in_valid(fifo_in_valid), .fifo_in_ready(fifo_in_ready),
    .fifo_in_data(fifo_in_data), .busy(busy), .dma_end(dma_end)
  );

  int checks = 0, failures = 0, end_cnt = 0;
  bit finished = 0;

  logic [31:0] mem [0:2047];
  logic [31:0] src [0:255];
  int src_idx = 0;
  bit src_en = 0, in_hs = 0;
  int seg_buf [0:139];
  int seg_len [0:139];

  // observed and expected traces
  bit          log_wr [0:LOGN-1];
  logic [31:0] log_addr [0:LOGN-1], log_data [0:LOGN-1];
  logic [3:0]  log_strb [0:LOGN-1];
  int log_n = 0;
  bit          exp_wr [0:LOGN-1];
  logic [31:0] exp_addr [0:LOGN-1], exp_data [0:LOGN-1];
  logic [3:0]  exp_strb [0:LOGN-1];
  int exp_n = 0;
  logic [31:0] out_data [0:LOGN-1], eout_data [0:LOGN-1];
  logic [3:0]  out_keep [0:LOGN-1], eout_keep [0:LOGN-1];
  int out_n = 0, eout_n = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes(int o, int rem);
    int tk = (4 - o < rem) ? 4 - o : rem;
    logic [3:0] s = 0;
    for (int b = 0; b < 4; b++) if (b >= o && b < o + tk) s[b] = 1'b1;
    return s;
  endfunction

  // memory model: one read in flight, random ready and latency
  int pend = 0, pdly = 0;
  logic [31:0] paddr = 0;
  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend != 0) begin
        if (pdly == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = mem[paddr[12:2]]; pend = 0;
        end else pdly--;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (log_n < LOGN) begin
          log_wr[log_n] = mem_req_write; log_addr[log_n] = mem_req_addr;
          log_data[log_n] = mem_req_wdata; log_strb[log_n] = mem_req_strb;
          log_n++;
        end
        if (mem_req_write) begin
          for (int b = 0; b < 4; b++)
            if (mem_req_strb[b]) mem[mem_req_addr[12:2]][8*b +: 8] = mem_req_wdata[8*b +: 8];
        end else begin
          pend = 1; pdly = $urandom % 3; paddr = mem_req_addr;
        end
      end
    end
  end

  initial begin
    fifo_out_ready = 0;
    forever begin
      @(negedge clk);
      fifo_out_ready = ($urandom % 3) != 0;
      if (fifo_out_valid && fifo_out_ready && out_n < LOGN) begin
        out_data[out_n] = fifo_out_data; out_keep[out_n] = fifo_out_keep; out_n++;
      end
    end
  end

  initial begin
    fifo_in_valid = 0; fifo_in_data = 0;
    forever begin
      @(negedge clk);
      if (in_hs) begin src_idx++; in_hs = 0; end
      fifo_in_valid = src_en && (($urandom % 4) != 0);
      fifo_in_data = src[src_idx % 256];
      if (fifo_in_valid && fifo_in_ready) in_hs = 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (dma_end) end_cnt++;
  end

  task automatic cfg_write(bit sel, logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic pulse_resp();
    @(negedge clk); resp_done = 1;
    @(negedge clk); resp_done = 0;
  endtask

  task automatic build(int n, bit use_end);
    for (int i = 0; i < n; i++) begin
      bit last = use_end && (i == n - 1);
      mem[i*4]   = last ? 32'd0 : 32'(i*16 + 16);
      mem[i*4+1] = 32'(seg_buf[i]);
      mem[i*4+2] = 32'(seg_len[i]);
      mem[i*4+3] = (32'(i) << 16) | (last ? 32'd2 : 32'd1);
    end
  endtask

  task automatic compute_exp(int n, bit m2f, int off0, bit use_end);
    int cnt = use_end ? n : ((n < MAXD) ? n : MAXD);
    int o = off0, jw = 0;
    exp_n = 0; eout_n = 0;
    for (int i = 0; i < cnt; i++) begin
      int wa = seg_buf[i] & ~3;
      int rem = seg_len[i];
      for (int k = 0; k < 4; k++) begin
        exp_wr[exp_n] = 0; exp_addr[exp_n] = 32'(i*16 + 4*k); exp_n++;
      end
      while (rem > 0) begin
        logic [3:0] s = lanes(o, rem);
        int tk = (4 - o < rem) ? 4 - o : rem;
        exp_addr[exp_n] = 32'(wa);
        if (m2f) begin
          exp_wr[exp_n] = 0;
          eout_data[eout_n] = mem[wa >> 2]; eout_keep[eout_n] = s; eout_n++;
        end else begin
          exp_wr[exp_n] = 1; exp_data[exp_n] = src[jw]; exp_strb[exp_n] = s; jw++;
        end
        exp_n++;
        wa += 4; rem -= tk; o = 0;
      end
    end
  endtask

  task automatic compare(string tag);
    int bad = -1;
    check(log_n == exp_n, {tag, " request count"}, 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (bad < 0 && (log_wr[i] != exp_wr[i] || log_addr[i] != exp_addr[i] ||
          (exp_wr[i] && (log_data[i] != exp_data[i] || log_strb[i] != exp_strb[i]))))
        bad = i;
    end
    if (bad >= 0)
      check(0, {tag, " request trace"}, log_addr[bad] ^ 32'(log_strb[bad]),
            exp_addr[bad] ^ 32'(exp_strb[bad]));
    else check(1, tag, 0, 0);
    check(out_n == eout_n, {tag, " fifo_out beat count"}, 32'(out_n), 32'(eout_n));
    bad = -1;
    for (int i = 0; i < eout_n && i < out_n; i++)
      if (bad < 0 && (out_data[i] != eout_data[i] || out_keep[i] != eout_keep[i])) bad = i;
    if (bad >= 0) check(0, {tag, " fifo_out data/keep"}, out_data[bad], eout_data[bad]);
  endtask

  task automatic run(int n, bit m2f, bit align, int off, bit use_end, string tag);
    int e0;
    int wait_c = 0;
    for (int i = 1024; i < 2048; i++) mem[i] = $urandom;
    for (int i = 0; i < 256; i++) src[i] = $urandom;
    build(n, use_end);
    compute_exp(n, m2f, align ? off : 0, use_end);
    src_en = 0; @(negedge clk); src_idx = 0; in_hs = 0;
    log_n = 0; out_n = 0; e0 = end_cnt;
    cfg_write(0, 32'h0);
    cfg_write(1, 32'h1 | (32'(m2f) << 1) | (32'h3 << 2) | (32'(align) << 4) | (32'(off & 3) << 5));
    src_en = 1;
    repeat (6) @(negedge clk);
    // R2: armed but no request before resp_done
    check(busy == 1 && log_n == 0, {tag, " R2 armed wait"}, 32'(log_n), 0);
    pulse_resp();
    while (end_cnt == e0 && wait_c < 20000) begin @(negedge clk); wait_c++; end
    repeat (5) @(negedge clk);
    check(end_cnt == e0 + 1, {tag, " R9 single dma_end"}, 32'(end_cnt - e0), 1);
    check(busy == 0, {tag, " R9 idle after end"}, 32'(busy), 0);
    compare(tag);
    src_en = 0;
  endtask

  initial begin
    void'($urandom(32'd20241));
    #1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && dma_end == 0 && mem_req_valid == 0 && fifo_out_valid == 0
          && fifo_in_ready == 0, "R1 reset state", 32'(busy), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R2: resp_done while idle is ignored
    pulse_resp();
    repeat (4) @(negedge clk);
    check(busy == 0 && log_n == 0, "R2 resp_done ignored when idle", 32'(busy), 0);

    // R5 aligned single segment, memory to fifo
    seg_buf[0] = 32'h1000; seg_len[0] = 8;
    run(1, 1, 0, 0, 1, "R5 R3 m2f aligned");
    // R6 R7 R8 offset 3, odd lengths, zero-length middle segment
    seg_buf[0] = 32'h1003; seg_len[0] = 7;
    seg_buf[1] = 32'h1040; seg_len[1] = 0;
    seg_buf[2] = 32'h1080; seg_len[2] = 5;
    run(3, 0, 1, 3, 1, "R6 R7 R8 f2m offset");
    // R7 offset field ignored without align enable; R4 chain walk
    seg_buf[0] = 32'h1000; seg_len[0] = 6;
    seg_buf[1] = 32'h1040; seg_len[1] = 9;
    run(2, 1, 0, 2, 1, "R7 R4 offset ignored");
    // R8 first-beat offset with length fitting in one beat
    seg_buf[0] = 32'h1001; seg_len[0] = 2;
    run(1, 1, 1, 1, 1, "R8 short partial");

    // random mixes
    for (int r = 0; r < 10; r++) begin
      int n = 1 + $urandom % 5;
      bit al = 1'($urandom % 2);
      int of = $urandom % 4;
      for (int i = 0; i < n; i++) begin
        seg_buf[i] = 32'h1000 + 64*i + ((i == 0 && al) ? of : 0);
        seg_len[i] = $urandom % 21;
      end
      run(n, 1'($urandom % 2), al, of, 1, "R4 R5 R6 R12 random");
    end

    // R11 chain limit: no end flag anywhere
    for (int i = 0; i < 130; i++) begin seg_buf[i] = 32'h1000; seg_len[i] = 0; end
    run(130, 0, 0, 0, 0, "R11 chain limit");

    // R10 abort mid-transfer
    begin
      int e0, l0;
      for (int i = 0; i < 3; i++) begin seg_buf[i] = 32'h1000 + 64*i; seg_len[i] = 20; end
      build(3, 1);
      log_n = 0; e0 = end_cnt; src_idx = 0; in_hs = 0;
      cfg_write(0, 32'h0);
      cfg_write(1, 32'h1);
      src_en = 1;
      pulse_resp();
      while (log_n < 7) @(negedge clk);
      cfg_write(1, 32'h0);
      check(busy == 0, "R10 idle after abort", 32'(busy), 0);
      repeat (2) @(negedge clk);
      l0 = log_n;
      repeat (40) @(negedge clk);
      check(end_cnt == e0, "R10 no dma_end on abort", 32'(end_cnt - e0), 0);
      check(log_n == l0, "R10 no requests after abort", 32'(log_n), 32'(l0));
      src_en = 0;
    end
    seg_buf[0] = 32'h1000; seg_len[0] = 12;
    run(1, 0, 0, 0, 1, "R10 restart after abort");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule